// File: doc/BRIEF.md
# Flash Query and Status Lane Replicator

This block formats the read word that a parallel flash bank returns while it is in identifier mode, query-table mode or status mode. The bank may be built from one, two or four identical devices placed side by side on the data bus, and each device may run narrower than its widest data mode. The block rescales the bus offset into a per-device table index. It then forms one device's answer and copies that answer into every device lane of the bank. When the access is wider than the bank, it packs several bank-wide answers into one word.

The read mode, the bus offset and the access width arrive with the configuration: bank, device and maximum-device widths in bytes. The result is registered and appears one clock later. When the device width is left at zero, a simpler compatibility scheme applies: the index comes from the low offset byte only, the identifier answers are fixed byte pairs, and the answers are not replicated. The query table is generated inside the block from the sector size and the block count.

Top module: `flq_read_fmt`

## Requirements
- R1: `rd_data` is a register that reflects the inputs sampled one clock earlier. A cycle with `rst_n` low clears it to zero.
- R2: Byte lanes at or above the access width (`acc_bytes`, 1, 2 or 4) read as zero.
- R3: With a nonzero device width, the table index is the offset shifted right by log2(bank) + log2(max device) − log2(device). A `dev_max_bytes` of zero means the same value as the device width.
- R4: A query index above 0x52 returns zero, and table entries that are not defined read as zero.
- R5: If the device width is below the maximum device width, the query byte is repeated into every byte instead of being padded with zero. This holds only for device width 1; any other narrow combination returns zero.
- R6: Within one bank-wide answer, byte lane j carries byte (j mod device width) of the single-device answer.
- R7: In identifier mode (`rd_mode` = 1), only bits 7:0 of the index are decoded: 0 gives `id_mfr`, 1 gives `id_dev`, and any other value gives zero.
- R8: When the access is wider than the bank, bank-width chunk k is answered for offset + k·bank and placed at bytes k·bank and up.
- R9: In status mode (`rd_mode` = 0), `stat_byte` fills every byte lane whose position is a multiple of the device width, and the other lanes are zero. With device width zero, it fills byte 0, and also byte 2 when the access is 4 bytes.
- R10: With device width zero, the index is offset[7:0] divided by the bank width. Identifier index 0 returns {`leg_hi0`,`leg_lo0`} and index 1 returns {`leg_hi1`,`leg_lo1`}, high byte first. A query returns the table byte alone.
- R11: The query table (`rd_mode` = 2) holds 0x51, 0x52, 0x59 at 0x10..0x12 and 0x01 at 0x13. At 0x2A it holds the write-buffer exponent: 8 for a 1-byte bank, 11 otherwise. The size and region fields are derived from the per-device block count.
- R12: `rd_mode` = 3 returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rd_ofs | input | 16 | Bus byte offset of the read |
| acc_bytes | input | 3 | Access width in bytes (1, 2, 4) |
| rd_mode | input | 2 | 0 status, 1 identifier, 2 query, 3 none |
| stat_byte | input | 8 | Current status byte |
| id_mfr | input | 16 | Manufacturer code |
| id_dev | input | 16 | Device code |
| leg_hi0 | input | 8 | Compatibility pair 0, high byte |
| leg_lo0 | input | 8 | Compatibility pair 0, low byte |
| leg_hi1 | input | 8 | Compatibility pair 1, high byte |
| leg_lo1 | input | 8 | Compatibility pair 1, low byte |
| bank_bytes | input | 3 | Bank width in bytes (1, 2, 4) |
| dev_bytes | input | 3 | Device width in bytes (0 = unset, 1, 2, 4) |
| dev_max_bytes | input | 3 | Maximum device width (0 = same as device) |
| rd_data | output | 32 | Registered read word |

## Verification
The bench sweeps every legal combination of bank, device and maximum-device width, in every mode, at every access width. Indices run across the whole table and past its end, and the bits below the index shift are scrambled. A wrong shift amount would read a neighbouring table entry. A padded narrow answer would show zero bytes in the upper lanes, and a wrong chunk stride would repeat one entry across a wide access. Identifier offsets with bits above bit 7 set confirm that the upper index bits are masked. Compatibility-mode reads confirm that the status byte lands in byte 2 and that identifier pairs are not replicated.

// File: rtl/flq_pkg.sv
// Shared definitions for the flash query/status read formatter.
// Assumes all width inputs are 0, 1, 2 or 4 bytes.
package flq_pkg;

    typedef enum logic [1:0] {
        RM_STATUS = 2'b00,
        RM_IDENT  = 2'b01,
        RM_QUERY  = 2'b10,
        RM_NONE   = 2'b11
    } rd_mode_e;

    // Highest valid query-table index; larger indices read as zero.
    localparam int QT_LAST = 'h52;

    // log2 of a byte count of 1, 2 or 4 (0 maps to 0).
    function automatic logic [1:0] bytes_log2(input logic [2:0] n);
        case (n)
            3'd2:    return 2'd1;
            3'd4:    return 2'd2;
            default: return 2'd0;
        endcase
    endfunction

endpackage

// File: rtl/flq_table.sv
// Query-table ROM of one device.
// The content is computed from the sector size, the total block count, the bank width
// and the number of devices sharing the bank. Assumes power-of-two geometry and
// BLOCKS_LOG2 >= 2.
module flq_table #(
    parameter int SECTOR_LOG2 = 16,
    parameter int BLOCKS_LOG2 = 6
) (
    input  logic [6:0] idx,
    input  logic [1:0] b_l2,
    input  logic [1:0] lanes_l2,
    output logic [7:0] data
);

    localparam logic [31:0] SECTOR_BYTES = 32'd1 << SECTOR_LOG2;

    logic [31:0] bpd_m1;
    logic [7:0]  size_l2;

    // Per-device geometry derived from the number of devices in the bank.
    always_comb begin
        bpd_m1  = (32'd1 << (5'(BLOCKS_LOG2) - 5'(lanes_l2))) - 32'd1;
        size_l2 = 8'(SECTOR_LOG2 + BLOCKS_LOG2) - 8'(lanes_l2);
    end

    // Table lookup.
    always_comb begin
        case (idx)
            7'h10: data = 8'h51;
            7'h11: data = 8'h52;
            7'h12: data = 8'h59;
            7'h13: data = 8'h01;
            7'h15: data = 8'h31;
            7'h1B: data = 8'h45;
            7'h1C: data = 8'h55;
            7'h1F: data = 8'h07;
            7'h20: data = 8'h07;
            7'h21: data = 8'h0A;
            7'h23: data = 8'h04;
            7'h24: data = 8'h04;
            7'h25: data = 8'h04;
            7'h27: data = size_l2;
            7'h28: data = 8'h02;
            7'h2A: data = (b_l2 == 2'd0) ? 8'd8 : 8'd11;
            7'h2C: data = 8'h01;
            7'h2D: data = bpd_m1[7:0];
            7'h2E: data = bpd_m1[15:8];
            7'h2F: data = SECTOR_BYTES[15:8];
            7'h30: data = SECTOR_BYTES[23:16];
            7'h31: data = 8'h50;
            7'h32: data = 8'h52;
            7'h33: data = 8'h49;
            7'h34: data = 8'h31;
            7'h35: data = 8'h30;
            7'h3F: data = 8'h01;
            default: data = 8'h00;
        endcase
    end

endmodule

// File: rtl/flq_slice.sv
// One bank-width answer for one offset in identifier or query mode.
// It rescales the offset into a device index, forms the single-device answer,
// and copies that answer across the device lanes of the bank.
// Lanes at or above the bank width are zero.
module flq_slice #(
    parameter int OFS_W       = 16,
    parameter int SECTOR_LOG2 = 16,
    parameter int BLOCKS_LOG2 = 6
) (
    input  logic [OFS_W-1:0] ofs,
    input  logic             is_ident,
    input  logic             legacy,
    input  logic [1:0]       b_l2,
    input  logic [1:0]       d_l2,
    input  logic [1:0]       m_l2,
    input  logic [15:0]      id_mfr,
    input  logic [15:0]      id_dev,
    input  logic [7:0]       leg_hi0,
    input  logic [7:0]       leg_lo0,
    input  logic [7:0]       leg_hi1,
    input  logic [7:0]       leg_lo1,
    output logic [31:0]      chunk
);
    import flq_pkg::*;

    logic [2:0]       shift_amt;
    logic [OFS_W-1:0] idx;
    logic             in_tbl;
    logic [1:0]       lanes_l2;
    logic [7:0]       tbl_byte;
    logic [31:0]      single;
    logic [31:0]      spread;
    logic [31:0]      compat;

    // Offset to table index, in scaled and compatibility forms.
    always_comb begin
        shift_amt = 3'(b_l2) + 3'(m_l2) - 3'(d_l2);
        idx       = legacy ? (OFS_W'(ofs[7:0]) >> b_l2) : (ofs >> shift_amt);
        in_tbl    = (idx <= OFS_W'(QT_LAST));
        lanes_l2  = legacy ? 2'd0 : (b_l2 - d_l2);
    end

    flq_table #(
        .SECTOR_LOG2(SECTOR_LOG2),
        .BLOCKS_LOG2(BLOCKS_LOG2)
    ) u_tbl (
        .idx     (idx[6:0]),
        .b_l2    (b_l2),
        .lanes_l2(lanes_l2),
        .data    (tbl_byte)
    );

    // Answer of a single device before bank replication.
    always_comb begin
        if (is_ident) begin
            case (idx[7:0])
                8'd0:    single = {16'h0, id_mfr};
                8'd1:    single = {16'h0, id_dev};
                default: single = 32'h0;
            endcase
        end else if (!in_tbl) begin
            single = 32'h0;
        end else if (d_l2 != m_l2) begin
            single = (d_l2 == 2'd0) ? {4{tbl_byte}} : 32'h0;
        end else begin
            single = {24'h0, tbl_byte};
        end
    end

    // Copy device-width slices across the bank lanes.
    always_comb begin
        for (int j = 0; j < 4; j++) begin
            logic [1:0] src;
            src = 2'(j) & ((2'd1 << d_l2) - 2'd1);
            spread[j*8 +: 8] = (3'(j) < (3'd1 << b_l2)) ? single[src*8 +: 8] : 8'h00;
        end
    end

    // Compatibility answer: fixed pairs or an unreplicated table byte.
    always_comb begin
        if (is_ident) begin
            case (idx[7:0])
                8'd0:    compat = {16'h0, leg_hi0, leg_lo0};
                8'd1:    compat = {16'h0, leg_hi1, leg_lo1};
                default: compat = 32'h0;
            endcase
        end else begin
            compat = in_tbl ? {24'h0, tbl_byte} : 32'h0;
        end
    end

    // Select the path for this configuration.
    always_comb chunk = legacy ? compat : spread;

endmodule

// File: rtl/flq_read_fmt.sv
// Read-word formatter for a bank of parallel flash devices in identifier,
// query or status mode. It builds four bank-width chunks at successive offsets,
// packs them from the low byte upward, applies the status fill and the access
// mask, and registers the result.
// Assumes device width <= bank width and device width <= maximum device width.
module flq_read_fmt #(
    parameter int OFS_W       = 16,
    parameter int SECTOR_LOG2 = 16,
    parameter int BLOCKS_LOG2 = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [OFS_W-1:0] rd_ofs,
    input  logic [2:0]       acc_bytes,
    input  logic [1:0]       rd_mode,
    input  logic [7:0]       stat_byte,
    input  logic [15:0]      id_mfr,
    input  logic [15:0]      id_dev,
    input  logic [7:0]       leg_hi0,
    input  logic [7:0]       leg_lo0,
    input  logic [7:0]       leg_hi1,
    input  logic [7:0]       leg_lo1,
    input  logic [2:0]       bank_bytes,
    input  logic [2:0]       dev_bytes,
    input  logic [2:0]       dev_max_bytes,
    output logic [31:0]      rd_data
);
    import flq_pkg::*;

    localparam int NCHUNK = 4;

    rd_mode_e         mode;
    logic [1:0]       b_l2;
    logic [1:0]       d_l2;
    logic [1:0]       m_l2;
    logic             legacy;
    logic [NCHUNK-1:0][31:0] chunk;
    logic [31:0]      packed_w;
    logic [31:0]      stat_w;
    logic [31:0]      word_nxt;

    // Decode the configuration into log2 form.
    always_comb begin
        mode   = rd_mode_e'(rd_mode);
        b_l2   = bytes_log2(bank_bytes);
        d_l2   = bytes_log2(dev_bytes);
        m_l2   = (dev_max_bytes == 3'd0) ? d_l2 : bytes_log2(dev_max_bytes);
        legacy = (dev_bytes == 3'd0);
    end

    // One slice per bank-width chunk of a 32-bit access.
    for (genvar k = 0; k < NCHUNK; k++) begin : g_chunk
        logic [OFS_W-1:0] ofs_k;
        always_comb ofs_k = rd_ofs + (OFS_W'(k) << b_l2);

        flq_slice #(
            .OFS_W      (OFS_W),
            .SECTOR_LOG2(SECTOR_LOG2),
            .BLOCKS_LOG2(BLOCKS_LOG2)
        ) u_slice (
            .ofs     (ofs_k),
            .is_ident(mode == RM_IDENT),
            .legacy  (legacy),
            .b_l2    (b_l2),
            .d_l2    (d_l2),
            .m_l2    (m_l2),
            .id_mfr  (id_mfr),
            .id_dev  (id_dev),
            .leg_hi0 (leg_hi0),
            .leg_lo0 (leg_lo0),
            .leg_hi1 (leg_hi1),
            .leg_lo1 (leg_lo1),
            .chunk   (chunk[k])
        );
    end

    // Pack chunk bytes: word byte n comes from chunk n/bank, byte n%bank.
    always_comb begin
        for (int n = 0; n < 4; n++) begin
            logic [1:0] ck;
            logic [1:0] cb;
            ck = 2'(n) >> b_l2;
            cb = 2'(n) & ((2'd1 << b_l2) - 2'd1);
            packed_w[n*8 +: 8] = legacy ? chunk[0][n*8 +: 8] : chunk[ck][cb*8 +: 8];
        end
    end

    // Status fill per device lane, or the compatibility layout.
    always_comb begin
        for (int n = 0; n < 4; n++) begin
            logic hit;
            if (legacy)
                hit = (n == 0) || ((n == 2) && (acc_bytes == 3'd4));
            else
                hit = ((2'(n) & ((2'd1 << d_l2) - 2'd1)) == 2'd0);
            stat_w[n*8 +: 8] = hit ? stat_byte : 8'h00;
        end
    end

    // Mode select and access-width mask.
    always_comb begin
        for (int n = 0; n < 4; n++) begin
            logic [7:0] b;
            case (mode)
                RM_STATUS: b = stat_w[n*8 +: 8];
                RM_IDENT,
                RM_QUERY:  b = packed_w[n*8 +: 8];
                default:   b = 8'h00;
            endcase
            word_nxt[n*8 +: 8] = (3'(n) < acc_bytes) ? b : 8'h00;
        end
    end

    // Output register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) rd_data <= '0;
        else        rd_data <= word_nxt;
    end

endmodule

// File: rtl/flq_read_fmt_chk.sv
// Property checker for flq_read_fmt, attached by bind.
module flq_read_fmt_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [2:0]  acc_bytes,
    input logic [1:0]  rd_mode,
    input logic [7:0]  stat_byte,
    input logic [2:0]  dev_bytes,
    input logic [2:0]  dev_max_bytes,
    input logic [31:0] rd_data
);

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> rd_data == 32'h0);

    // R2
    byte_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_bytes == 3'd1 |=> rd_data[31:8] == 24'h0);

    // R9
    stat_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_mode == 2'd0 && dev_bytes == 3'd1 && acc_bytes == 3'd4)
        |=> rd_data == {4{$past(stat_byte)}});

    // R9
    stat_compat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_mode == 2'd0 && dev_bytes == 3'd0 && acc_bytes == 3'd4)
        |=> rd_data == {8'h0, $past(stat_byte), 8'h0, $past(stat_byte)});

    // R5
    narrow_unsup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_mode == 2'd2 && dev_bytes == 3'd2 && dev_max_bytes == 3'd4)
        |=> rd_data == 32'h0);

    // R12
    idle_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_mode == 2'd3 |=> rd_data == 32'h0);

endmodule

bind flq_read_fmt flq_read_fmt_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .acc_bytes    (acc_bytes),
    .rd_mode      (rd_mode),
    .stat_byte    (stat_byte),
    .dev_bytes    (dev_bytes),
    .dev_max_bytes(dev_max_bytes),
    .rd_data      (rd_data)
);

// File: tb/flq_read_fmt_tb.sv
`timescale 1ns/1ps
module flq_read_fmt_tb;

    localparam int SL = 16;
    localparam int BL = 6;
    localparam logic [15:0] MFR = 16'hA789;
    localparam logic [15:0] DEV = 16'h1C35;
    localparam logic [7:0]  H0 = 8'h12, L0 = 8'h34, H1 = 8'h56, L1 = 8'h78;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] rd_ofs = '0;
    logic [2:0]  acc_bytes = 3'd1;
    logic [1:0]  rd_mode = '0;
    logic [7:0]  stat_byte = '0;
    logic [2:0]  bank_bytes = 3'd1, dev_bytes = 3'd1, dev_max_bytes = 3'd1;
    logic [31:0] rd_data;

    int n_tests = 0;
    int n_fail  = 0;

    always #2 clk = ~clk;

    flq_read_fmt #(.OFS_W(16), .SECTOR_LOG2(SL), .BLOCKS_LOG2(BL)) u_dut (
        .clk(clk), .rst_n(rst_n), .rd_ofs(rd_ofs), .acc_bytes(acc_bytes),
        .rd_mode(rd_mode), .stat_byte(stat_byte), .id_mfr(MFR), .id_dev(DEV),
        .leg_hi0(H0), .leg_lo0(L0), .leg_hi1(H1), .leg_lo1(L1),
        .bank_bytes(bank_bytes), .dev_bytes(dev_bytes),
        .dev_max_bytes(dev_max_bytes), .rd_data(rd_data)
    );

    function automatic int lg(int v);
        return (v == 4) ? 2 : ((v == 2) ? 1 : 0);
    endfunction

    function automatic int ref_tbl(int i, int B, int D);
        int lanes = (D == 0) ? 1 : B / D;
        int bpd   = (1 << BL) / lanes;
        case (i)
            'h10: return 'h51;  'h11: return 'h52;  'h12: return 'h59;
            'h13: return 'h01;  'h15: return 'h31;  'h1B: return 'h45;
            'h1C: return 'h55;  'h1F: return 'h07;  'h20: return 'h07;
            'h21: return 'h0A;  'h23: return 'h04;  'h24: return 'h04;
            'h25: return 'h04;  'h27: return SL + BL - lg(lanes);
            'h28: return 'h02;  'h2A: return (B == 1) ? 8 : 11;
            'h2C: return 'h01;  'h2D: return (bpd - 1) & 255;
            'h2E: return ((bpd - 1) >> 8) & 255;
            'h2F: return ((1 << SL) >> 8) & 255;
            'h30: return ((1 << SL) >> 16) & 255;
            'h31: return 'h50;  'h32: return 'h52;  'h33: return 'h49;
            'h34: return 'h31;  'h35: return 'h30;  'h3F: return 'h01;
            default: return 0;
        endcase
    endfunction

    // One bank-wide answer for a single offset (scaled addressing).
    function automatic logic [31:0] ref_single(bit isid, int off, int B, int D, int M);
        int sh = lg(B) + lg(M) - lg(D);
        int bo = off >> sh;
        logic [31:0] r = '0;
        for (int j = 0; j < B; j++) begin
            int b;
            if (isid) begin
                int s = bo & 255;
                int v = (s == 0) ? int'(MFR) : ((s == 1) ? int'(DEV) : 0);
                b = (v >> (8 * (j % D))) & 255;
            end else if (bo > 'h52) begin
                b = 0;
            end else if (D != M) begin
                b = (D == 1) ? ref_tbl(bo, B, D) : 0;
            end else begin
                b = (j % D == 0) ? ref_tbl(bo, B, D) : 0;
            end
            r[j*8 +: 8] = 8'(b);
        end
        return r;
    endfunction

    function automatic logic [31:0] ref_word(int mode, int off, int W, int B, int D, int M, int st);
        logic [31:0] r = '0;
        for (int n = 0; n < W; n++) begin
            int b = 0;
            if (mode == 0) begin
                if (D != 0) b = (n % D == 0) ? st : 0;
                else        b = (n == 0 || (n == 2 && W == 4)) ? st : 0;
            end else if (mode != 3) begin
                if (D == 0) begin
                    int bo = (off & 255) >> lg(B);
                    int v;
                    if (mode == 1)
                        v = (bo == 0) ? {H0, L0} : ((bo == 1) ? {H1, L1} : 0);
                    else
                        v = (bo > 'h52) ? 0 : ref_tbl(bo, B, 0);
                    b = (v >> (8 * n)) & 255;
                end else begin
                    logic [31:0] c = ref_single(mode == 1, off + (n / B) * B, B, D, M);
                    b = int'(c[(n % B)*8 +: 8]);
                end
            end
            r[n*8 +: 8] = 8'(b);
        end
        return r;
    endfunction

    // Drive at a falling edge, sample at the next falling edge (one register).
    task automatic run_vec(int mode, int off, int W, int B, int D, int M, int st,
                           logic [31:0] exp, string tag);
        rd_mode = 2'(mode); rd_ofs = 16'(off); acc_bytes = 3'(W);
        bank_bytes = 3'(B); dev_bytes = 3'(D); dev_max_bytes = 3'(M);
        stat_byte = 8'(st);
        @(negedge clk);
        n_tests++;
        if (rd_data !== exp) begin
            n_fail++;
            $display("FAIL %s: mode=%0d ofs=%h W=%0d B=%0d D=%0d M=%0d got %h exp %h",
                     tag, mode, off, W, B, D, M, rd_data, exp);
        end
    endtask

    task automatic check_now(logic [31:0] exp, string tag);
        n_tests++;
        if (rd_data !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h exp %h", tag, rd_data, exp);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check_now(32'h0, "R1 reset state");
        rst_n = 1'b1;

        // Directed cases with literal expectations.
        run_vec(2, 'h10, 1, 1, 1, 1, 0, 32'h51, "R11 Q");
        run_vec(2, 'h12, 1, 1, 1, 1, 0, 32'h59, "R11 Y");
        run_vec(2, 'h13, 1, 1, 1, 1, 0, 32'h01, "R11 cmd set");
        run_vec(2, 'h2A, 1, 1, 1, 1, 0, 32'h08, "R11 buffer exp bank1");
        run_vec(2, 'h2A << 1, 2, 2, 2, 2, 0, 32'h0000000B, "R11 buffer exp bank2");
        run_vec(2, 'h10 << 3, 4, 4, 1, 2, 0, 32'h51515151, "R3 R5 narrow repeat");
        run_vec(2, 'h10 << 4, 4, 4, 2, 4, 0, 32'h0, "R5 unsupported narrow");
        run_vec(2, 'h10 << 2, 4, 4, 2, 2, 0, 32'h00510051, "R6 bank replicate");
        run_vec(2, 'h10, 4, 1, 1, 1, 0, 32'h01595251, "R8 packed chunks");
        run_vec(2, 'h53, 1, 1, 1, 1, 0, 32'h0, "R4 past table");
        run_vec(1, 'h400, 2, 2, 2, 2, 0, {16'h0, MFR}, "R7 upper index bits");
        run_vec(1, 'h2, 2, 2, 2, 2, 0, {16'h0, DEV}, "R7 device code");
        run_vec(0, 0, 4, 4, 2, 2, 'hC3, 32'h00C300C3, "R9 status lanes");
        run_vec(0, 0, 4, 4, 0, 0, 'h80, 32'h00800080, "R9 compat status");
        run_vec(1, 'h2, 2, 2, 0, 0, 0, {16'h0, H1, L1}, "R10 compat pair");
        run_vec(0, 0, 1, 4, 1, 1, 'h5A, 32'h0000005A, "R2 width mask");
        run_vec(3, 'h10, 4, 4, 4, 4, 'hFF, 32'h0, "R12 no mode");

        // Reset in mid-run clears the output.
        rd_mode = 2'd0; stat_byte = 8'hEE; acc_bytes = 3'd4;
        rst_n = 1'b0;
        @(negedge clk);
        check_now(32'h0, "R1 reset mid-run");
        rst_n = 1'b1;

        // Sweep every legal width combination.
        for (int bl = 0; bl < 3; bl++) begin
            int B = 1 << bl;
            for (int ds = 0; ds < 4; ds++) begin
                int D = (ds == 0) ? 0 : (1 << (ds - 1));
                if (D > B) continue;
                for (int ms = 0; ms < 3; ms++) begin
                    int M = (D == 0) ? 0 : (1 << ms);
                    if (D == 0 && ms > 0) continue;
                    if (D != 0 && M < D) continue;
                    for (int W = 1; W <= 4; W = W * 2) begin
                        for (int mode = 0; mode < 4; mode++) begin
                            int sh = (D == 0) ? lg(B) : lg(B) + lg(M) - lg(D);
                            string tag;
                            case (mode)
                                0: tag = "R2/R9 status";
                                1: tag = (D == 0) ? "R10 compat id" : "R3/R6/R7/R8 id";
                                2: tag = (D == 0) ? "R10 compat query" : "R3/R4/R5/R6/R8/R11 query";
                                default: tag = "R12 no mode";
                            endcase
                            for (int ix = 0; ix < 'h5B; ix++) begin
                                int idx = (ix < 'h58) ? ix : ('h100 + ix - 'h58);
                                int off = (idx << sh) | ((idx * 5) & ((1 << sh) - 1));
                                int st  = (idx * 37 + 1) & 255;
                                run_vec(mode, off, W, B, D, M, st,
                                        ref_word(mode, off, W, B, D, M, st), tag);
                            end
                        end
                    end
                end
            end
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: got timeout exp completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule